// File: doc/BRIEF.md
# Sequential Combination Lock Controller

This block is a clocked finite state machine that releases a lock only after a user enters a fixed series of three dial operations in the right order. Each operation has a turning direction (one bit, 1 = right, 0 = left) and a dial position (a 6-bit field, legal positions 0 to 39). An operation is presented on the input bus together with a strobe that is high for one cycle. The machine moves only when an operation arrives. It does not move because clock cycles pass.

The secret series is right-13, then left-22, then right-3. The order matters and so does the direction of each step. A wrong operation sends the machine back to its start. There is one exception: if the wrong operation is itself the first step of the series, the machine counts it as a fresh start. Once the lock is open it ignores all further operations. Only the relock input or the synchronous reset brings it back to the start.

The four states, with their 2-bit codes on `lock_state`, are ST_IDLE (00, nothing relevant entered), ST_GOT1 (01, first step done), ST_GOT2 (10, first two steps done) and ST_OPEN (11, lock released).

The transitions, each taken on a cycle where the strobe is high and relock is low, are:
- T_START: ST_IDLE to ST_GOT1 on right-13.
- T_SECOND: ST_GOT1 to ST_GOT2 on left-22.
- T_THIRD: ST_GOT2 to ST_OPEN on right-3.
- T_RESTART: ST_GOT1 or ST_GOT2 to ST_GOT1 on right-13.
- T_MISS: any non-open state to ST_IDLE on any other operation.
- T_RELOCK: any state to ST_IDLE on relock.

Top module: `seq_lock_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is ST_IDLE (`lock_state` = 00) and `unlocked` = 0.
- R2: `lock_state` reports the current state as ST_IDLE = 00, ST_GOT1 = 01, ST_GOT2 = 10, ST_OPEN = 11, and it changes one cycle after the edge that samples the operation.
- R3: On a cycle where `op_valid` is low (and `relock` and `rst` are low), the state does not change.
- R4: In ST_IDLE, the operation right-13 (`op_dir`=1, `op_pos`=13) moves the machine to ST_GOT1.
- R5: In ST_GOT1, left-22 (`op_dir`=0, `op_pos`=22) moves the machine to ST_GOT2.
- R6: In ST_GOT2, right-3 (`op_dir`=1, `op_pos`=3) moves the machine to ST_OPEN.
- R7: In any non-open state, an operation that is not the expected next step moves the machine to ST_IDLE. If that operation is right-13, the machine moves to ST_GOT1 instead.
- R8: A dial position above 39 (40 to 63) is always a wrong operation.
- R9: Direction is part of each step: a step with the correct position but the opposite direction is wrong.
- R10: In ST_OPEN, valid operations of any value leave the state at ST_OPEN.
- R11: `relock` high at a clock edge (with `rst` low) moves the machine to ST_IDLE from any state, and it takes priority over a valid operation in the same cycle.
- R12: `unlocked` is 1 in ST_OPEN and 0 in the other three states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | High for one cycle when an operation is presented |
| op_dir | input | 1 | Turning direction: 1 = right, 0 = left |
| op_pos | input | 6 | Dial position of the operation |
| relock | input | 1 | Returns the machine to ST_IDLE |
| unlocked | output | 1 | High while the lock is open |
| lock_state | output | 2 | Current state code |

## Verification
The bench takes the machine into each of the four states. In each one it applies every possible operation, both directions and all 64 position codes. So it sees every correct step, the same positions with the wrong direction, the out-of-range positions, and the restart value right-13 in every state. A separate pattern holds `op_valid` low while the bus carries the correct next step. This shows that the strobe alone gates progress. Relock is then applied from every state, both alone and together with a correct operation, to show that it takes priority over advancing the series.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int POS_W     = 6;
    localparam int STEP_CNT  = 3;
    localparam int STATE_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'b00,
        ST_GOT1 = 2'b01,
        ST_GOT2 = 2'b10,
        ST_OPEN = 2'b11
    } lock_state_t;

    typedef struct packed {
        logic             dir;
        logic [POS_W-1:0] pos;
    } dial_op_t;

endpackage

// File: rtl/lock_step_match.sv
module lock_step_match
    import lock_pkg::*;
#(
    parameter int          DIAL_MAX = 39,
    parameter logic        WANT_DIR = 1'b1,
    parameter logic [POS_W-1:0] WANT_POS = 6'd13
) (
    input  dial_op_t op,
    output logic     hit
);
    logic in_range;

    always_comb begin
        in_range = (int'(op.pos) <= DIAL_MAX);
        hit      = in_range && (op.dir == WANT_DIR) && (op.pos == WANT_POS);
    end

endmodule

// File: rtl/lock_fsm_core.sv
module lock_fsm_core
    import lock_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic                relock,
    input  logic [STEP_CNT-1:0] step_hit,
    output lock_state_t         state
);
    lock_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (relock) begin
            state_nx = ST_IDLE;
        end else if (op_valid) begin
            unique case (state)
                ST_IDLE: state_nx = step_hit[0] ? ST_GOT1 : ST_IDLE;
                ST_GOT1: begin
                    if (step_hit[1])      state_nx = ST_GOT2;
                    else if (step_hit[0]) state_nx = ST_GOT1;
                    else                  state_nx = ST_IDLE;
                end
                ST_GOT2: begin
                    if (step_hit[2])      state_nx = ST_OPEN;
                    else if (step_hit[0]) state_nx = ST_GOT1;
                    else                  state_nx = ST_IDLE;
                end
                ST_OPEN: state_nx = ST_OPEN;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lock_out_dec.sv
module lock_out_dec
    import lock_pkg::*;
(
    input  lock_state_t        state,
    output logic               unlocked,
    output logic [STATE_W-1:0] lock_state
);
    always_comb begin
        lock_state = state;
        unique case (state)
            ST_IDLE: unlocked = 1'b0;
            ST_GOT1: unlocked = 1'b0;
            ST_GOT2: unlocked = 1'b0;
            ST_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end

endmodule

// File: rtl/seq_lock_ctrl.sv
module seq_lock_ctrl
    import lock_pkg::*;
#(
    parameter int                        DIAL_MAX  = 39,
    parameter logic [STEP_CNT-1:0]       STEP_DIRS = 3'b101,
    parameter logic [STEP_CNT*POS_W-1:0] STEP_POSS = {6'd3, 6'd22, 6'd13}
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic               op_dir,
    input  logic [POS_W-1:0]   op_pos,
    input  logic               relock,
    output logic               unlocked,
    output logic [STATE_W-1:0] lock_state
);
    dial_op_t            cur_op;
    logic [STEP_CNT-1:0] step_hit;
    lock_state_t         state;

    assign cur_op.dir = op_dir;
    assign cur_op.pos = op_pos;

    for (genvar g = 0; g < STEP_CNT; g++) begin : g_step
        lock_step_match #(
            .DIAL_MAX (DIAL_MAX),
            .WANT_DIR (STEP_DIRS[g]),
            .WANT_POS (STEP_POSS[g*POS_W +: POS_W])
        ) u_match (
            .op  (cur_op),
            .hit (step_hit[g])
        );
    end

    lock_fsm_core u_fsm (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .relock   (relock),
        .step_hit (step_hit),
        .state    (state)
    );

    lock_out_dec u_out (
        .state      (state),
        .unlocked   (unlocked),
        .lock_state (lock_state)
    );

endmodule

// File: rtl/lock_chk.sv
module lock_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic       op_dir,
    input logic [5:0] op_pos,
    input logic       relock,
    input logic       unlocked,
    input logic [1:0] lock_state
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (lock_state == 2'b00 && !unlocked));

    // R3
    strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !relock) |=> $stable(lock_state));

    // R4
    first_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !relock && op_dir && op_pos == 6'd13 && lock_state != 2'b11)
        |=> lock_state == 2'b01);

    // R6
    open_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> ($past(lock_state) == 2'b10 && $past(op_valid)
                             && $past(op_dir) && $past(op_pos) == 6'd3));

    // R10
    open_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_state == 2'b11 && !relock) |=> (lock_state == 2'b11 && unlocked));

    // R11
    relock_chk: assert property (@(posedge clk) disable iff (rst)
        relock |=> (lock_state == 2'b00 && !unlocked));

endmodule

bind seq_lock_ctrl lock_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_dir     (op_dir),
    .op_pos     (op_pos),
    .relock     (relock),
    .unlocked   (unlocked),
    .lock_state (lock_state)
);

// File: tb/seq_lock_ctrl_bench.sv
module seq_lock_ctrl_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic       op_dir = 1'b0;
    logic [5:0] op_pos = 6'd0;
    logic       relock = 1'b0;
    logic       unlocked;
    logic [1:0] lock_state;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seq_lock_ctrl u_seq_lock_ctrl (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .op_dir     (op_dir),
        .op_pos     (op_pos),
        .relock     (relock),
        .unlocked   (unlocked),
        .lock_state (lock_state)
    );

    // Expected next state from the requirements (codes 0..3).
    function automatic int exp_next(int s, bit d, int p);
        if (s == 3) return 3;                         // R10
        if (s == 1 && !d && p == 22) return 2;        // R5
        if (s == 2 && d && p == 3) return 3;          // R6
        if (d && p == 13) return 1;                   // R4, R7
        return 0;                                     // R7, R8, R9
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apply_op(bit d, int p);
        @(negedge clk);
        op_valid = 1'b1;
        op_dir   = d;
        op_pos   = 6'(p);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic go_to(int s);
        do_reset();
        if (s >= 1) apply_op(1'b1, 13);
        if (s >= 2) apply_op(1'b0, 22);
        if (s >= 3) apply_op(1'b1, 3);
    endtask

    function automatic string tag_for(int s, bit d, int p);
        if (s == 3) return "R10";
        if (p > 39) return "R8";
        if ((p == 13 && !d) || (p == 22 && d) || (p == 3 && !d)) return "R9";
        if (s == 0 && d && p == 13) return "R4";
        if (s == 1 && !d && p == 22) return "R5";
        if (s == 2 && d && p == 3) return "R6";
        return "R7";
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1, R12: reset state
        do_reset();
        check("R1 state", int'(lock_state), 0);
        check("R12 unlocked", int'(unlocked), 0);

        // R2: path through the series reports each code
        apply_op(1'b1, 13);
        check("R2 code GOT1", int'(lock_state), 1);
        apply_op(1'b0, 22);
        check("R2 code GOT2", int'(lock_state), 2);
        apply_op(1'b1, 3);
        check("R2 code OPEN", int'(lock_state), 3);
        check("R12 open", int'(unlocked), 1);

        // R3: correct next step on the bus without strobe does nothing
        for (int s = 0; s < 3; s++) begin
            go_to(s);
            @(negedge clk);
            op_dir = (s != 1);
            op_pos = (s == 0) ? 6'd13 : (s == 1) ? 6'd22 : 6'd3;
            repeat (3) @(negedge clk);
            check("R3 hold", int'(lock_state), s);
        end

        // Exhaustive sweep: every state x every operation
        for (int s = 0; s < 4; s++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 64; p++) begin
                    int e;
                    go_to(s);
                    apply_op(d[0], p);
                    e = exp_next(s, d[0], p);
                    check(tag_for(s, d[0], p), int'(lock_state), e);
                    check("R12 sweep", int'(unlocked), (e == 3) ? 1 : 0);
                end
            end
        end

        // R11: relock alone, and relock with the correct next step
        for (int s = 0; s < 4; s++) begin
            go_to(s);
            @(negedge clk);
            relock = 1'b1;
            @(negedge clk);
            relock = 1'b0;
            check("R11 relock", int'(lock_state), 0);
            go_to(s);
            @(negedge clk);
            relock   = 1'b1;
            op_valid = 1'b1;
            op_dir   = (s != 1);
            op_pos   = (s == 0) ? 6'd13 : (s == 1) ? 6'd22 : 6'd3;
            @(negedge clk);
            relock   = 1'b0;
            op_valid = 1'b0;
            check("R11 priority", int'(lock_state), 0);
            check("R11 unlocked", int'(unlocked), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule